// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds eight independent 32-bit down-counters behind a word-wide register port. Each channel has its own interrupt line. Software sets up a channel by writing a reload value and two match words, then sets that channel's nibble in a shared control word. An enabled channel decrements on every clock, or only on cycles where the external tick input is high if its external-clock bit is set. When a channel is at zero, its next tick reloads it from the reload register instead of decrementing, and its interrupt line inverts if interrupts are allowed for that channel.

Each channel is driven by a two-state machine. In `CH_STOPPED` the counter holds. The *start* transition to `CH_COUNTING` happens on the clock edge after the enable bit is seen set, so the clock selection and interrupt settings written in the same control word are already in force before the first decrement. In `CH_COUNTING` the counter runs. The *halt* transition back to `CH_STOPPED` happens on the clock edge after the enable bit is seen clear, and on that edge the counter is reloaded.

Bus reads are combinational and writes take effect on the clock edge. Accesses are 32 bits wide and must be word-aligned.

Top module: `timer_bank_top`

## Requirements
- R1: After reset, every register of every channel, the control word and the auxiliary word all read 0, and all eight interrupt outputs are 0.
- R2: Address map. Channels 0, 1 and 2 sit at 0x00, 0x10 and 0x20; channels 3 to 7 sit at 0x40, 0x50, 0x60, 0x70 and 0x80. Within a channel, the count register is at +0x0, reload at +0x4, match 1 at +0x8 and match 2 at +0xC. The control word is at 0x30. An auxiliary word at 0x34 is stored and read back but has no effect on counting.
- R3: Offsets 0x38 and 0x3C, any offset of 0x90 or above (including any address with bits above bit 7 set), and any misaligned address all read as 0, and writes to them change nothing.
- R4: Channel c owns control bits [4c+3:4c]. Within that nibble, bit 0 is enable, bit 1 selects the external tick, bit 2 is the overflow-interrupt enable and bit 3 is the pulse enable. The pulse bit is stored only for channels 4 to 7; for channels 0 to 3 it always reads back 0.
- R5: A write to the reload register stores the value and loads it into the counter on the same edge, whether or not the channel is enabled.
- R6: A write to the count register loads the counter only while the channel's enable bit is set; otherwise the write is ignored.
- R7: In bus-clock mode, the counter decrements by one on each edge. The first decrement happens on the second edge after the control write that sets the enable bit.
- R8: In external mode, the counter decrements only on edges where the external tick input is high. A control write that sets both enable and external mode therefore causes no decrement until a tick arrives.
- R9: A tick that finds the counter at 0 loads it from the reload register, so the count repeats with a period of reload+1 ticks.
- R10: At each reload-from-zero, the channel's interrupt output inverts if its overflow-interrupt bit is set or either of its match words is 0. If the overflow-interrupt bit is clear and both match words are nonzero, the interrupt output keeps its level.
- R11: On the edge after a control write that clears the enable bit, the counter is loaded from the reload register, and it then holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the bus-mode count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ext_tick | input | 1 | Synchronous one-cycle tick for external mode |
| irq | output | 8 | Per-channel toggling interrupt level |

## Verification
The bench targets the split address map and checks that the fourth channel is found at 0x40 and not at 0x30. A decoder without the hole would alias the control word onto a channel. It counts edges exactly around enable and disable, so an off-by-one start, a missing reload on halt, or a decrement during the start cycle shows up as a wrong count. It checks interrupt parity over many random reload and wait pairs, and it includes one case where both match words are nonzero and the overflow bit is clear, so a design that toggles on every wrap is caught. It also checks that the pulse bit is masked on the low channels and that a count write is dropped while the channel is disabled.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;

    localparam int NIB_W     = 4;
    localparam int EN_BIT    = 0;
    localparam int EXT_BIT   = 1;
    localparam int OVF_BIT   = 2;
    localparam int PULSE_BIT = 3;

    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_RELOAD = 2'd1,
        REG_MATCH1 = 2'd2,
        REG_MATCH2 = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CH_STOPPED  = 1'b0,
        CH_COUNTING = 1'b1
    } ch_state_e;

endpackage

// File: rtl/tbank_decode.sv
module tbank_decode
    import timer_bank_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_CH    = 8,
    parameter int LOW_GROUP = 3
) (
    input  logic [ADDR_W-1:0]         addr_i,
    output logic                      ch_hit_o,
    output logic [$clog2(NUM_CH)-1:0] ch_idx_o,
    output reg_sel_e                  reg_sel_o,
    output logic                      ctrl_hit_o,
    output logic                      aux_hit_o
);
    localparam int IDX_W = $clog2(NUM_CH);

    logic [3:0] blk;
    logic [1:0] word;
    logic       in_window;

    assign blk       = addr_i[7:4];
    assign word      = addr_i[3:2];
    assign in_window = ((addr_i >> 8) == '0) && (addr_i[1:0] == 2'b00);
    assign reg_sel_o = reg_sel_e'(word);

    always_comb begin
        ch_hit_o   = 1'b0;
        ch_idx_o   = '0;
        ctrl_hit_o = 1'b0;
        aux_hit_o  = 1'b0;
        if (in_window) begin
            if (int'(blk) < LOW_GROUP) begin
                ch_hit_o = 1'b1;
                ch_idx_o = IDX_W'(blk);
            end else if (int'(blk) == LOW_GROUP) begin
                ctrl_hit_o = (word == 2'd0);
                aux_hit_o  = (word == 2'd1);
            end else if (int'(blk) <= NUM_CH) begin
                ch_hit_o = 1'b1;
                ch_idx_o = IDX_W'(blk - 4'd1);
            end
        end
    end
endmodule

// File: rtl/tbank_channel.sv
module tbank_channel
    import timer_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       ctrl_i,
    input  logic             ext_tick_i,
    input  logic             wr_count_i,
    input  logic             wr_reload_i,
    input  logic             wr_match1_i,
    input  logic             wr_match2_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] match1_o,
    output logic [CNT_W-1:0] match2_o,
    output logic             irq_o
);
    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, reload_q, m1_q, m2_q;
    logic             irq_q;
    logic             en, tick, run, wrap, toggle_ok;

    assign en        = ctrl_i[EN_BIT];
    assign tick      = ctrl_i[EXT_BIT] ? ext_tick_i : 1'b1;
    assign run       = (state_q == CH_COUNTING) && en;
    assign wrap      = run && tick && (cnt_q == '0) && !wr_reload_i && !wr_count_i;
    assign toggle_ok = ctrl_i[OVF_BIT] || (m1_q == '0) || (m2_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_STOPPED;
        else        state_q <= state_d;
    end

    // transitions: start / halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED:  if (en)  state_d = CH_COUNTING;
            CH_COUNTING: if (!en) state_d = CH_STOPPED;
            default:     state_d = CH_STOPPED;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
            m1_q     <= '0;
            m2_q     <= '0;
            irq_q    <= 1'b0;
        end else begin
            if (wr_match1_i) m1_q <= wdata_i;
            if (wr_match2_i) m2_q <= wdata_i;
            if (wr_reload_i) begin
                reload_q <= wdata_i;
                cnt_q    <= wdata_i;
            end else if ((state_q == CH_COUNTING) && !en) begin
                cnt_q <= reload_q;
            end else if (wr_count_i && en) begin
                cnt_q <= wdata_i;
            end else if (run && tick) begin
                cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
            end
            if (wrap && toggle_ok) irq_q <= ~irq_q;
        end
    end

    assign count_o  = cnt_q;
    assign reload_o = reload_q;
    assign match1_o = m1_q;
    assign match2_o = m2_q;
    assign irq_o    = irq_q;

    // R5
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload_i |=> (cnt_q == $past(wdata_i)));

    // R7
    bus_decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CH_COUNTING) && en && !ctrl_i[EXT_BIT] && (cnt_q != '0)
         && !wr_reload_i && !wr_count_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R8
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctrl_i[EXT_BIT] && !ext_tick_i && (state_q == CH_COUNTING)
         && !wr_reload_i && !wr_count_i) |=> $stable(cnt_q));

    // R6
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == CH_STOPPED) && !wr_reload_i && !(wr_count_i && en))
        |=> $stable(cnt_q));

    // R10
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_q) |-> ($past(cnt_q) == '0));
endmodule

// File: rtl/timer_bank_top.sv
module timer_bank_top
    import timer_bank_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 12,
    parameter int LOW_GROUP   = 3,
    parameter int PULSE_FIRST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ext_tick,
    output logic [NUM_CH-1:0] irq
);
    localparam int DATA_W = 32;
    localparam int CTRL_W = NUM_CH * NIB_W;
    localparam int IDX_W  = $clog2(NUM_CH);

    function automatic logic [CTRL_W-1:0] ctrl_mask_f();
        logic [CTRL_W-1:0] m;
        m = '1;
        for (int c = 0; c < NUM_CH; c++)
            if (c < PULSE_FIRST) m[c*NIB_W + PULSE_BIT] = 1'b0;
        return m;
    endfunction
    localparam logic [CTRL_W-1:0] CTRL_MASK = ctrl_mask_f();

    logic              ch_hit, ctrl_hit, aux_hit, wr_en;
    logic [IDX_W-1:0]  ch_idx;
    reg_sel_e          reg_sel;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] aux_q;
    logic [CNT_W-1:0]  cnt_a [NUM_CH];
    logic [CNT_W-1:0]  rld_a [NUM_CH];
    logic [CNT_W-1:0]  m1_a  [NUM_CH];
    logic [CNT_W-1:0]  m2_a  [NUM_CH];

    assign wr_en = bus_sel && bus_wr;

    tbank_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .LOW_GROUP(LOW_GROUP)) dec_i (
        .addr_i    (bus_addr),
        .ch_hit_o  (ch_hit),
        .ch_idx_o  (ch_idx),
        .reg_sel_o (reg_sel),
        .ctrl_hit_o(ctrl_hit),
        .aux_hit_o (aux_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            aux_q  <= '0;
        end else begin
            if (wr_en && ctrl_hit) ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_MASK;
            if (wr_en && aux_hit)  aux_q  <= bus_wdata;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic sel_me;
        assign sel_me = wr_en && ch_hit && (ch_idx == IDX_W'(c));
        tbank_channel #(.CNT_W(CNT_W)) ch_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_i     (ctrl_q[c*NIB_W +: 3]),
            .ext_tick_i (ext_tick),
            .wr_count_i (sel_me && (reg_sel == REG_COUNT)),
            .wr_reload_i(sel_me && (reg_sel == REG_RELOAD)),
            .wr_match1_i(sel_me && (reg_sel == REG_MATCH1)),
            .wr_match2_i(sel_me && (reg_sel == REG_MATCH2)),
            .wdata_i    (bus_wdata[CNT_W-1:0]),
            .count_o    (cnt_a[c]),
            .reload_o   (rld_a[c]),
            .match1_o   (m1_a[c]),
            .match2_o   (m2_a[c]),
            .irq_o      (irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (ctrl_hit)     bus_rdata = DATA_W'(ctrl_q);
            else if (aux_hit) bus_rdata = aux_q;
            else if (ch_hit) begin
                unique case (reg_sel)
                    REG_COUNT:  bus_rdata = DATA_W'(cnt_a[ch_idx]);
                    REG_RELOAD: bus_rdata = DATA_W'(rld_a[ch_idx]);
                    REG_MATCH1: bus_rdata = DATA_W'(m1_a[ch_idx]);
                    REG_MATCH2: bus_rdata = DATA_W'(m2_a[ch_idx]);
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

    // R4
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_hit) |=> (ctrl_q == ($past(bus_wdata[CTRL_W-1:0]) & CTRL_MASK)));

    // R3
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !ch_hit && !ctrl_hit && !aux_hit) |-> (bus_rdata == '0));

    // R3
    ctrl_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && ctrl_hit)) |=> (ctrl_q == $past(ctrl_q)));
endmodule

// File: tb/timer_bank_top_tb_top.sv
`timescale 1ns/1ps
module timer_bank_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 1'b0;
    logic [7:0]  irq;
    logic [7:0]  irq_snap;
    int          tests = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    timer_bank_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_tick(ext_tick), .irq(irq)
    );

    function automatic logic [11:0] base(int c);
        return (c < 3) ? 12'(c * 16) : 12'(c * 16 + 16);
    endfunction
    function automatic int exp_cnt(int r, int d);
        return r - (d % (r + 1));
    endfunction
    function automatic int exp_tog(int r, int d);
        return d / (r + 1);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        irq_snap = irq;
        bus_sel = 1'b0;
    endtask

    initial begin
        logic [31:0] v;
        logic        b;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 4; r++) begin
                rd(base(c) + 12'(r * 4), v);
                chk("R1 reg", v, 32'h0);
            end
        rd(12'h030, v); chk("R1 ctrl", v, 32'h0);
        rd(12'h034, v); chk("R1 aux", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R4 nibble layout, pulse masked on channels 0-3
        wr(12'h030, 32'hEEEE_EEEE);
        rd(12'h030, v); chk("R4 pulse mask", v, 32'hEEEE_6666);
        wr(12'h030, 32'h0);

        // R2 / R5 map and reload loads counter
        for (int c = 0; c < 8; c++) wr(base(c) + 12'h4, 32'h1000 + 32'(c));
        for (int c = 0; c < 8; c++) begin
            rd(base(c) + 12'h4, v); chk("R2 reload map", v, 32'h1000 + 32'(c));
            rd(base(c), v);         chk("R5 count loaded", v, 32'h1000 + 32'(c));
        end
        wr(12'h034, 32'hA5A5_A5A5);
        rd(12'h034, v); chk("R2 aux readback", v, 32'hA5A5_A5A5);
        rd(12'h000, v); chk("R2 aux no effect", v, 32'h1000);

        // R3 unmapped
        wr(12'h038, 32'hFFFF_FFFF); rd(12'h038, v); chk("R3 0x38", v, 32'h0);
        wr(12'h03C, 32'hFFFF_FFFF); rd(12'h03C, v); chk("R3 0x3C", v, 32'h0);
        wr(12'h090, 32'hFFFF_FFFF); rd(12'h090, v); chk("R3 0x90", v, 32'h0);
        wr(12'h005, 32'hDEAD_BEEF); rd(12'h005, v); chk("R3 misaligned", v, 32'h0);
        wr(12'h104, 32'h0000_0077);
        rd(12'h004, v); chk("R3 no alias", v, 32'h1000);
        rd(12'h030, v); chk("R3 ctrl intact", v, 32'h0);

        // R6 count write ignored while disabled
        wr(base(1), 32'h55);
        rd(base(1), v); chk("R6 disabled write", v, 32'h1001);

        // R7 / R9 / R10 channel 0, reload 3, overflow IE
        wr(12'h004, 32'd3);
        wr(12'h030, 32'h5);
        for (int k = 1; k <= 10; k++) begin
            rd(12'h000, v);
            chk("R7/R9 count", v, 32'(exp_cnt(3, k - 1)));
            chk("R10 irq parity", 32'(irq_snap[0]), 32'(exp_tog(3, k - 1) % 2));
        end
        // R11 disable reloads and holds
        wr(12'h030, 32'h0);
        rd(12'h000, v); chk("R11 reload on halt", v, 32'd3);
        repeat (4) @(negedge clk);
        rd(12'h000, v); chk("R11 hold", v, 32'd3);

        // R6 count write while enabled
        wr(12'h030, 32'h1);
        wr(12'h000, 32'd100);
        rd(12'h000, v); chk("R6 enabled write", v, 32'd99);
        rd(12'h000, v); chk("R6 continues", v, 32'd98);
        wr(12'h030, 32'h0);
        rd(12'h000, v); chk("R11 halt", v, 32'd3);

        // R10 no toggle: overflow clear, both matches nonzero (channel 2)
        wr(12'h028, 32'd5);
        wr(12'h02C, 32'd7);
        wr(12'h024, 32'd2);
        b = irq[2];
        wr(12'h030, 32'h100);
        for (int k = 0; k < 10; k++) rd(12'h020, v);
        chk("R10 no toggle", 32'(irq_snap[2]), 32'(b));
        wr(12'h030, 32'h0);
        wr(12'h028, 32'h0);
        wr(12'h02C, 32'h0);

        // R8 external tick, channel 5
        wr(base(5) + 12'h4, 32'd10);
        wr(12'h030, 32'h0030_0000);
        for (int k = 0; k < 5; k++) rd(base(5), v);
        chk("R8 no tick no count", v, 32'd10);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ext_tick = 1'b1;
            @(negedge clk); ext_tick = 1'b0;
        end
        rd(base(5), v); chk("R8 three ticks", v, 32'd7);
        wr(12'h030, 32'h0);

        // random runs (R7, R9, R10, R11)
        for (int it = 0; it < 24; it++) begin
            int c, r, k;
            logic [31:0] ovf;
            c   = int'($urandom % 8);
            r   = int'($urandom % 30);
            k   = 1 + int'($urandom % 70);
            ovf = $urandom % 2;
            wr(base(c) + 12'h4, 32'(r));
            b = irq[c];
            wr(12'h030, (32'h1 | (ovf << 2)) << (4 * c));
            if (k > 1) repeat (k - 1) @(negedge clk);
            rd(base(c), v);
            chk("R9 random count", v, 32'(exp_cnt(r, k - 1)));
            chk("R10 random irq", 32'(irq_snap[c] ^ b), 32'(exp_tog(r, k - 1) % 2));
            wr(12'h030, 32'h0);
            rd(base(c), v);
            chk("R11 random halt", v, 32'(r));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog all-requirements act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule